// File: doc/BRIEF.md
# Pipelined Converter Digit Combiner

This block is the digital back end of a dual-channel, ten-bit pipelined converter. Each channel delivers raw decisions from eight redundant stages, which have three levels each, and one final four-level stage. The decisions for one sample reach the block on different clock edges, because the sample moves down the analog pipeline over several cycles. The block delays each stage's digit so that all nine digits of a sample meet on the same cycle. It then sums them with overlapping binary weights. The redundancy in the fine stages absorbs comparator offsets, so every code from 0 to 1023 can be reached.

The resulting word is registered with a selectable coding, either offset binary or two's complement. It is presented on a parallel bus with a drive qualifier, which stands in for a three-state pin driver. Any out-of-range code from a fine stage is folded to its largest legal value, and the event is recorded in a sticky flag for that channel.

Top module: `pipeadc_correct`

## Requirements
- R1: Fine stage k (k = 1..8) presents its digit on bits [2k-1:2k-2] of the channel's fine bus, and its legal codes are 0, 1 and 2. The final-stage digit is on the 2-bit last bus and may take any code from 0 to 3.
- R2: With format low, the output word is offset binary. Its value is the sum of each fine digit times 2^(9-k), plus the final digit. It spans 0 to 1023, and redundant digit sets with the same sum give the same word.
- R3: Call the rising edge that captures the digits of fine stages 1 and 2 the sample edge T. Stages 3 and 4 are captured at T+1, stages 5 and 6 at T+2, stages 7 and 8 at T+3, and the final stage at T+4. The word appears after edge T+5 and not before.
- R4: A new sample may start on every edge. Consecutive samples, whose fields are interleaved on the buses, each produce their own word on consecutive cycles.
- R5: With format high, the word is the offset-binary word with bit 9 inverted (two's complement). The format is sampled by the same edge that loads the output word, so a change shows on the next registered output.
- R6: When the output enable is low, the drive qualifier is low and the data bus reads zero in the same cycle. The stored word is kept, and it reappears when the enable returns high.
- R7: A fine-stage code of 3 is summed as 2. It sets the channel's error flag from the edge that captures it, and the flag stays set until reset.
- R8: The two channels are independent. Stimulus on channel A changes neither the word nor the error flag of channel B, and the reverse also holds.
- R9: An active-low reset acts asynchronously. It clears both stored words and both error flags, so the data buses read zero while enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_twos | input | 1 | Output coding: 0 offset binary, 1 two's complement |
| oe | input | 1 | Output enable; low releases the data buses |
| a_fine | input | 16 | Channel A fine-stage digits, 2 bits per stage |
| a_last | input | 2 | Channel A final-stage digit |
| b_fine | input | 16 | Channel B fine-stage digits, 2 bits per stage |
| b_last | input | 2 | Channel B final-stage digit |
| a_data | output | 10 | Channel A word, zero while released |
| a_drive | output | 1 | Channel A bus drive qualifier |
| b_data | output | 10 | Channel B word, zero while released |
| b_drive | output | 1 | Channel B bus drive qualifier |
| a_err | output | 1 | Channel A sticky illegal-code flag |
| b_err | output | 1 | Channel B sticky illegal-code flag |

## Verification
A sample's word is due five edges after its sample edge. The bench drives each stage's field from the sample it belongs to, on the edge given in R3, and samples every output at the falling edge after that fifth edge. Before the first sample arrives, it also checks that the idle word is still present. Format and enable effects are checked at different points: format one edge after the change, and enable a moment after the change with no edge in between. Error flags are checked at two points: just before the capturing edge, to confirm the flag is not yet set, and just after it, to confirm it is.

// File: rtl/adcc_pkg.sv
package adcc_pkg;
  localparam int DIG_W = 2;
  typedef logic [DIG_W-1:0] digit_t;
  localparam digit_t DIG_BAD = 2'd3;
  localparam digit_t DIG_TOP = 2'd2;

  function automatic logic digit_bad(input digit_t d);
    return d == DIG_BAD;
  endfunction

  function automatic digit_t digit_fold(input digit_t d);
    return (d == DIG_BAD) ? DIG_TOP : d;
  endfunction

  // cycles a fine stage digit (0-based index) waits before the adder
  function automatic int stage_wait(input int idx, input int n_fine);
    return n_fine / 2 + 1 - idx / 2;
  endfunction
endpackage

// File: rtl/adcc_delay.sv
module adcc_delay #(
  parameter int W     = 2,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] tap [DEPTH];

  genvar i;
  for (i = 0; i < DEPTH; i++) begin : g_tap
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap[0] <= '0;
        else        tap[0] <= d;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap[i] <= '0;
        else        tap[i] <= tap[i-1];
      end
    end
  end

  assign q = tap[DEPTH-1];
endmodule

// File: rtl/adcc_channel.sv
module adcc_channel
  import adcc_pkg::*;
#(
  parameter int N_FINE = 8,
  parameter int FIN_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_FINE*DIG_W-1:0]   fine_bus,
  input  logic [FIN_W-1:0]          last_dig,
  input  logic                      fmt_twos,
  output logic                      illegal_now,
  output logic                      err,
  output logic [N_FINE+FIN_W-1:0]   sum_word,
  output logic [N_FINE+FIN_W-1:0]   word_q
);
  localparam int FINE_W = N_FINE * DIG_W;
  localparam int OUT_W  = N_FINE + FIN_W;
  localparam int MSB    = OUT_W - 1;

  logic [N_FINE-1:0] bad_vec;
  logic [FINE_W-1:0] aligned_bus;
  logic [FIN_W-1:0]  aligned_last;

  genvar k;
  for (k = 0; k < N_FINE; k++) begin : g_stage
    localparam int DLY = stage_wait(k, N_FINE);
    digit_t raw;
    digit_t folded;
    assign raw        = fine_bus[k*DIG_W +: DIG_W];
    assign bad_vec[k] = digit_bad(raw);
    assign folded     = digit_fold(raw);
    adcc_delay #(.W(DIG_W), .DEPTH(DLY)) u_dly (
      .clk(clk), .rst_n(rst_n), .d(folded),
      .q(aligned_bus[k*DIG_W +: DIG_W])
    );
  end

  adcc_delay #(.W(FIN_W), .DEPTH(1)) u_last_dly (
    .clk(clk), .rst_n(rst_n), .d(last_dig), .q(aligned_last)
  );

  function automatic logic [OUT_W-1:0] overlap_add(
    input logic [FINE_W-1:0] digs,
    input logic [FIN_W-1:0]  last
  );
    logic [OUT_W-1:0] acc;
    acc = OUT_W'(last);
    for (int s = 0; s < N_FINE; s++) begin
      acc = acc + (OUT_W'(digs[s*DIG_W +: DIG_W]) << (N_FINE - s + FIN_W - 2));
    end
    return acc;
  endfunction

  function automatic logic [OUT_W-1:0] apply_format(
    input logic [OUT_W-1:0] w,
    input logic             twos
  );
    return {w[MSB] ^ twos, w[MSB-1:0]};
  endfunction

  assign illegal_now = |bad_vec;
  assign sum_word    = overlap_add(aligned_bus, aligned_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           err <= 1'b0;
    else if (illegal_now) err <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= apply_format(sum_word, fmt_twos);
  end
endmodule

// File: rtl/pipeadc_correct.sv
module pipeadc_correct
  import adcc_pkg::*;
#(
  parameter int N_FINE = 8,
  parameter int FIN_W  = 2,
  localparam int FINE_W = N_FINE * DIG_W,
  localparam int OUT_W  = N_FINE + FIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_twos,
  input  logic              oe,
  input  logic [FINE_W-1:0] a_fine,
  input  logic [FIN_W-1:0]  a_last,
  input  logic [FINE_W-1:0] b_fine,
  input  logic [FIN_W-1:0]  b_last,
  output logic [OUT_W-1:0]  a_data,
  output logic              a_drive,
  output logic [OUT_W-1:0]  b_data,
  output logic              b_drive,
  output logic              a_err,
  output logic              b_err
);
  localparam int N_CH = 2;

  logic [N_CH-1:0][FINE_W-1:0] ch_fine;
  logic [N_CH-1:0][FIN_W-1:0]  ch_last;
  logic [N_CH-1:0]             ch_illegal;
  logic [N_CH-1:0]             ch_err;
  logic [N_CH-1:0][OUT_W-1:0]  ch_sum;
  logic [N_CH-1:0][OUT_W-1:0]  ch_word;

  assign ch_fine[0] = a_fine;
  assign ch_fine[1] = b_fine;
  assign ch_last[0] = a_last;
  assign ch_last[1] = b_last;

  genvar c;
  for (c = 0; c < N_CH; c++) begin : g_ch
    adcc_channel #(.N_FINE(N_FINE), .FIN_W(FIN_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .fine_bus(ch_fine[c]), .last_dig(ch_last[c]),
      .fmt_twos(fmt_twos),
      .illegal_now(ch_illegal[c]), .err(ch_err[c]),
      .sum_word(ch_sum[c]), .word_q(ch_word[c])
    );
  end

  assign a_drive = oe;
  assign b_drive = oe;
  assign a_data  = a_drive ? ch_word[0] : '0;
  assign b_data  = b_drive ? ch_word[1] : '0;
  assign a_err   = ch_err[0];
  assign b_err   = ch_err[1];
endmodule

// File: rtl/adcc_chk.sv
module adcc_chk #(
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fmt_twos,
  input logic             a_drive,
  input logic             b_drive,
  input logic [OUT_W-1:0] a_data,
  input logic [OUT_W-1:0] b_data,
  input logic             a_err,
  input logic             b_err,
  input logic [1:0]       illegal,
  input logic [OUT_W-1:0] sum_a,
  input logic [OUT_W-1:0] word_a
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R7
  a_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_err |=> a_err);
  // R7
  b_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_err |=> b_err);
  // R7
  a_bad_code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal[0] |=> a_err);
  // R7
  b_bad_code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal[1] |=> b_err);
  // R6
  a_released_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_drive |-> a_data == '0);
  // R6
  b_released_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !b_drive |-> b_data == '0);
  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && sum_a == $past(sum_a) && fmt_twos == $past(fmt_twos)) |=> $stable(word_a));
endmodule

bind pipeadc_correct adcc_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_twos(fmt_twos),
  .a_drive(a_drive), .b_drive(b_drive),
  .a_data(a_data), .b_data(b_data),
  .a_err(a_err), .b_err(b_err),
  .illegal(ch_illegal), .sum_a(ch_sum[0]), .word_a(ch_word[0])
);

// File: tb/pipeadc_correct_bench.sv
`timescale 1ns/1ps
module pipeadc_correct_bench;
  localparam int NV  = 10;
  localparam int LAT = 5;

  // {fine[15:0], last[1:0], offset-binary word[9:0]}
  localparam logic [27:0] VEC [NV] = '{
    {16'hAAAA, 2'd3, 10'd1023},
    {16'h0000, 2'd0, 10'd0},
    {16'h5555, 2'd0, 10'd510},
    {16'h5555, 2'd2, 10'd512},
    {16'h0002, 2'd0, 10'd512},
    {16'hAAA8, 2'd3, 10'd511},
    {16'hAAA1, 2'd3, 10'd511},
    {16'h8000, 2'd0, 10'd4},
    {16'h0000, 2'd1, 10'd1},
    {16'h0204, 2'd1, 10'd161}
  };

  logic clk = 1'b0, rst_n = 1'b0, fmt_twos = 1'b0, oe = 1'b1;
  logic [15:0] a_fine = '0, b_fine = '0;
  logic [1:0]  a_last = '0, b_last = '0;
  logic [9:0]  a_data, b_data;
  logic        a_drive, b_drive, a_err, b_err;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  pipeadc_correct u_pipeadc_correct (
    .clk(clk), .rst_n(rst_n), .fmt_twos(fmt_twos), .oe(oe),
    .a_fine(a_fine), .a_last(a_last), .b_fine(b_fine), .b_last(b_last),
    .a_data(a_data), .a_drive(a_drive), .b_data(b_data), .b_drive(b_drive),
    .a_err(a_err), .b_err(b_err)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [27:0] vec_at(input int s, input bit rev);
    if (s < 0 || s >= NV) return '0;
    return rev ? VEC[NV-1-s] : VEC[s];
  endfunction

  // buses for edge i: stage k field from sample i-(k-1)/2, last from i-4
  task automatic drive_cycle(input int i);
    logic [27:0] va, vb;
    for (int k = 0; k < 8; k++) begin
      va = vec_at(i - k/2, 1'b0);
      vb = vec_at(i - k/2, 1'b1);
      a_fine[2*k +: 2] = va[12 + 2*k +: 2];
      b_fine[2*k +: 2] = vb[12 + 2*k +: 2];
    end
    va = vec_at(i - 4, 1'b0);
    vb = vec_at(i - 4, 1'b1);
    a_last = va[11:10];
    b_last = vb[11:10];
  endtask

  task automatic run_table(input bit twos);
    fmt_twos = twos;
    a_fine = '0; b_fine = '0; a_last = '0; b_last = '0;
    repeat (LAT + 1) @(negedge clk);
    for (int i = 0; i < NV + LAT + 1; i++) begin
      if (i >= 1) begin
        logic [27:0] va, vb;
        logic [9:0]  ea, eb;
        va = vec_at(i - (LAT + 1), 1'b0);
        vb = vec_at(i - (LAT + 1), 1'b1);
        ea = va[9:0] ^ {twos, 9'd0};
        eb = vb[9:0] ^ {twos, 9'd0};
        // R1 R2 R3 R4 (and R5 when twos) on A, R8 on B
        check(twos ? "R5" : "R1 R2 R3 R4", "a_data", 32'(a_data), 32'(ea));
        check(twos ? "R5 R8" : "R8 R4", "b_data", 32'(b_data), 32'(eb));
      end
      drive_cycle(i);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R9: reset holds everything clear even with illegal codes on the inputs
    a_fine = 16'hFFFF; b_fine = 16'hFFFF; a_last = 2'd3; b_last = 2'd3;
    repeat (3) @(negedge clk);
    check("R9", "a_data in reset", 32'(a_data), 32'd0);
    check("R9", "b_data in reset", 32'(b_data), 32'd0);
    check("R9", "a_err in reset", 32'(a_err), 32'd0);
    check("R9", "b_err in reset", 32'(b_err), 32'd0);
    a_fine = '0; b_fine = '0; a_last = '0; b_last = '0;
    @(negedge clk);
    rst_n = 1'b1;

    run_table(1'b0);
    run_table(1'b1);

    // steady mid-scale on A, zero on B, offset binary
    fmt_twos = 1'b0;
    a_fine = 16'h5555; a_last = 2'd2; b_fine = '0; b_last = '0;
    repeat (LAT + 1) @(negedge clk);
    check("R2", "steady a_data", 32'(a_data), 32'd512);

    // R6: release and reassert the buses
    oe = 1'b0; #1;
    check("R6", "a_drive released", 32'(a_drive), 32'd0);
    check("R6", "a_data released", 32'(a_data), 32'd0);
    check("R6", "b_data released", 32'(b_data), 32'd0);
    repeat (2) @(negedge clk);
    oe = 1'b1; #1;
    check("R6", "a_drive back", 32'(a_drive), 32'd1);
    check("R6", "a_data back", 32'(a_data), 32'd512);

    // R5: format change shows only after the next edge
    @(negedge clk);
    fmt_twos = 1'b1; #1;
    check("R5", "a_data before edge", 32'(a_data), 32'd512);
    @(negedge clk);
    check("R5", "a_data twos", 32'(a_data), 32'd0);
    check("R5", "b_data twos", 32'(b_data), 32'd512);
    fmt_twos = 1'b0;

    // R7: one-cycle illegal code on A stage 3
    a_fine = 16'h0030; a_last = '0; #1;
    check("R7", "a_err before capture", 32'(a_err), 32'd0);
    @(negedge clk);
    a_fine = '0;
    check("R7", "a_err after capture", 32'(a_err), 32'd1);
    check("R8", "b_err untouched", 32'(b_err), 32'd0);
    repeat (4) @(negedge clk);
    check("R7", "a_err sticky", 32'(a_err), 32'd1);

    // R7: code 3 summed as 2 (A stage 1 -> 512, B stage 7 -> 8)
    a_fine = 16'h0003; b_fine = 16'h3000;
    repeat (LAT + 1) @(negedge clk);
    check("R7", "a_data folded", 32'(a_data), 32'd512);
    check("R7", "b_data folded", 32'(b_data), 32'd8);
    check("R7", "b_err set", 32'(b_err), 32'd1);

    // R9: asynchronous reset clears flags and words mid-run
    rst_n = 1'b0; #1;
    check("R9", "a_err cleared", 32'(a_err), 32'd0);
    check("R9", "b_err cleared", 32'(b_err), 32'd0);
    check("R9", "a_data cleared", 32'(a_data), 32'd0);
    a_fine = '0; b_fine = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule